// File: doc/BRIEF.md
# UART Interrupt Combiner with Mask and Receive-DMA Busy

This block gathers the interrupt causes of one serial port into a four-bit sticky source register, masks them, and drives a single level-sensitive interrupt line. Receive and transmit causes come from comparisons between FIFO fill counts and programmable thresholds. In single-byte (non-FIFO) operation a data-ready flag takes the place of the receive comparison. A receive-timeout pulse, a receive-error pulse and a modem-status pulse are further causes.

Software clears causes and programs the mask through a small write port. The block also produces a busy indication for a receive DMA engine. The data storage and all timers sit outside the block; they deliver counts, thresholds and one-cycle event pulses.

Top module: `uart_irq_combiner`

## Requirements
- R1: The source-pending vector `src_pend` uses bit 0 = receive, bit 1 = error, bit 2 = transmit, bit 3 = modem. `pend` equals `src_pend & ~mask`. `irq` is high exactly when `pend` is nonzero.
- R2: With `fifo_en` high, a clock edge at which `tx_count <= tx_thresh` sets bit 2.
- R3: With `fifo_en` high, a clock edge at which `rx_count >= rx_thresh` sets bit 0.
- R4: With `fifo_en` high, a clock edge at which `rx_count` is nonzero and `rx_tmo_en` is low sets bit 0, whatever the threshold.
- R5: With `fifo_en` low, bit 0 is set at an edge where `rx_ready` is high. The count comparisons of R2 to R4 set nothing in this mode.
- R6: At a clock edge, `rx_tmo_evt` sets bit 0, `rx_err_evt` sets bit 1 and `modem_evt` sets bit 3.
- R7: Source-pending bits are sticky. A set bit stays set after its cause goes away, until software clears it.
- R8: A write with `wr_sel` = 2'b00 (pending) clears, at that edge, every bit of `src_pend` and `pend` that is 1 in `wr_data`.
- R9: A write with `wr_sel` = 2'b01 (source-pending) clears, at that edge, every bit of `src_pend` that is 1 in `wr_data`.
- R10: A write with `wr_sel` = 2'b10 loads the mask from `wr_data`. `pend` and `irq` reflect the new mask from the cycle after the write edge. The mask is zero after reset.
- R11: When a set cause and a software clear hit the same bit at the same edge, the bit ends up set.
- R12: `dma_busy` is high exactly when `rx_mode` equals 2'b10 and `rx_count` is zero.
- R13: During and right after reset, `src_pend`, `pend` and `irq` are zero.
- R14: A write with `wr_sel` = 2'b11 changes neither `src_pend` nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO operation selected |
| rx_tmo_en | input | 1 | Receive-timeout interrupt enabled (control bit 7) |
| rx_mode | input | 2 | Receive transfer mode (control bits [1:0]); 2'b10 selects DMA |
| rx_count | input | CW | Receive FIFO fill count |
| rx_thresh | input | CW | Receive trigger threshold |
| tx_count | input | CW | Transmit FIFO fill count |
| tx_thresh | input | CW | Transmit trigger threshold |
| rx_ready | input | 1 | Non-FIFO receive data ready |
| rx_tmo_evt | input | 1 | Receive-timeout event pulse |
| rx_err_evt | input | 1 | Receive-error event pulse |
| modem_evt | input | 1 | Modem-status event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 pending, 01 source-pending, 10 mask, 11 none |
| wr_data | input | 4 | Write data, one bit per source |
| src_pend | output | 4 | Sticky source-pending vector |
| pend | output | 4 | Masked pending vector |
| irq | output | 1 | Level interrupt request |
| dma_busy | output | 1 | Receive DMA busy |

## Verification
A source bit that is set when it should not be, or lost when it should stay, shows on `src_pend` one edge after the cause. If it is unmasked, `irq` shows the same fault in that cycle. A mask register holding a wrong value appears only through `pend` and `irq`, from the cycle after the write. The masked-source cases are therefore checked with causes both present and absent. A wrong priority between set and clear is visible only when both happen at the same edge, so the bench drives that overlap on purpose. A bad `dma_busy` term is combinational and shows as soon as `rx_mode` or `rx_count` changes.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 4;

  localparam int SRC_RX  = 0;
  localparam int SRC_ERR = 1;
  localparam int SRC_TX  = 2;
  localparam int SRC_MDM = 3;

  typedef enum logic [1:0] {
    SEL_PEND = 2'b00,
    SEL_SRC  = 2'b01,
    SEL_MASK = 2'b10,
    SEL_NONE = 2'b11
  } wr_sel_e;

  localparam logic [1:0] RX_MODE_DMA = 2'b10;
endpackage

// File: rtl/uirq_src_detect.sv
module uirq_src_detect
  import uirq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic            fifo_en,
  input  logic            rx_tmo_en,
  input  logic [CW-1:0]   rx_count,
  input  logic [CW-1:0]   rx_thresh,
  input  logic [CW-1:0]   tx_count,
  input  logic [CW-1:0]   tx_thresh,
  input  logic            rx_ready,
  input  logic            rx_tmo_evt,
  input  logic            rx_err_evt,
  input  logic            modem_evt,
  output logic [NSRC-1:0] set_vec
);
  // Transmit trigger: fill level at or under the threshold.
  function automatic logic tx_level_hit(input logic [CW-1:0] cnt,
                                        input logic [CW-1:0] thr);
    return cnt <= thr;
  endfunction

  // Receive trigger: threshold reached, or any data with the timeout off.
  function automatic logic rx_level_hit(input logic [CW-1:0] cnt,
                                        input logic [CW-1:0] thr,
                                        input logic          tmo_on);
    logic reached, any_data;
    reached  = cnt >= thr;
    any_data = (cnt != '0) && !tmo_on;
    return reached || any_data;
  endfunction

  logic rx_cause, tx_cause;

  always_comb begin
    if (fifo_en) begin
      rx_cause = rx_level_hit(rx_count, rx_thresh, rx_tmo_en);
      tx_cause = tx_level_hit(tx_count, tx_thresh);
    end else begin
      rx_cause = rx_ready;
      tx_cause = 1'b0;
    end
  end

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_RX]  = rx_cause || rx_tmo_evt;
    set_vec[SRC_ERR] = rx_err_evt;
    set_vec[SRC_TX]  = tx_cause;
    set_vec[SRC_MDM] = modem_evt;
  end
endmodule

// File: rtl/uirq_src_reg.sv
module uirq_src_reg
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] src_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          src_q[i] <= 1'b0;
      else if (set_vec[i]) src_q[i] <= 1'b1;
      else if (clr_vec[i]) src_q[i] <= 1'b0;
    end
  end

  // R11: a set at an edge always leaves the bit high
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((src_q & $past(set_vec)) == $past(set_vec)));

  // R7: with no clear, no bit ever falls
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((src_q & $past(src_q)) == $past(src_q)));

  // R8/R9: cleared bits without a competing set go low
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((src_q & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NSRC-1:0] din,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= din;
  end

  // R10: a load takes the written value
  a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_q == $past(din)));

  // R14: without a load the mask holds
  a_r14_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mask_q));
endmodule

// File: rtl/uirq_dma_busy.sv
module uirq_dma_busy
  import uirq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [1:0]    rx_mode,
  input  logic [CW-1:0] rx_count,
  output logic          busy
);
  function automatic logic busy_fn(input logic [1:0] mode,
                                   input logic [CW-1:0] cnt);
    return (mode == RX_MODE_DMA) && (cnt == '0);
  endfunction

  always_comb busy = busy_fn(rx_mode, rx_count);
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uirq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic            rx_tmo_en,
  input  logic [1:0]      rx_mode,
  input  logic [CW-1:0]   rx_count,
  input  logic [CW-1:0]   rx_thresh,
  input  logic [CW-1:0]   tx_count,
  input  logic [CW-1:0]   tx_thresh,
  input  logic            rx_ready,
  input  logic            rx_tmo_evt,
  input  logic            rx_err_evt,
  input  logic            modem_evt,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] src_pend,
  output logic [NSRC-1:0] pend,
  output logic            irq,
  output logic            dma_busy
);
  // Named internal events for the assertions
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] mask_q;
  logic            clr_hit;
  logic            mask_wr;

  always_comb begin
    clr_hit = wr_en && ((wr_sel == SEL_PEND) || (wr_sel == SEL_SRC));
    mask_wr = wr_en && (wr_sel == SEL_MASK);
    clr_vec = clr_hit ? wr_data : '0;
  end

  uirq_src_detect #(.CW(CW)) u_detect (
    .fifo_en    (fifo_en),
    .rx_tmo_en  (rx_tmo_en),
    .rx_count   (rx_count),
    .rx_thresh  (rx_thresh),
    .tx_count   (tx_count),
    .tx_thresh  (tx_thresh),
    .rx_ready   (rx_ready),
    .rx_tmo_evt (rx_tmo_evt),
    .rx_err_evt (rx_err_evt),
    .modem_evt  (modem_evt),
    .set_vec    (set_vec)
  );

  uirq_src_reg u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .src_q   (src_pend)
  );

  uirq_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mask_wr),
    .din    (wr_data),
    .mask_q (mask_q)
  );

  uirq_dma_busy #(.CW(CW)) u_dma (
    .rx_mode  (rx_mode),
    .rx_count (rx_count),
    .busy     (dma_busy)
  );

  always_comb begin
    pend = src_pend & ~mask_q;
    irq  = |pend;
  end

  // R2: transmit level in FIFO mode raises the transmit source
  a_r2_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (tx_count <= tx_thresh)) |=> src_pend[SRC_TX]);

  // R5: data-ready in non-FIFO mode raises the receive source
  a_r5_nonfifo_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_ready) |=> src_pend[SRC_RX]);

  // R6: error pulse raises the error source
  a_r6_err_evt: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt |=> src_pend[SRC_ERR]);

  // R12: busy only with an empty receive FIFO
  a_r12_dma_empty: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |-> (rx_count == '0));

  // R1: a masked source never reaches the line
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_pend & ~mask_q) == '0) |-> !irq);
endmodule

// File: tb/uart_irq_combiner_tb.sv
`timescale 1ns/1ps
module uart_irq_combiner_tb;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, rx_tmo_en = 0;
  logic [1:0] rx_mode = 0;
  logic [CW-1:0] rx_count = 0, rx_thresh = 0, tx_count = 0, tx_thresh = 0;
  logic rx_ready = 0, rx_tmo_evt = 0, rx_err_evt = 0, modem_evt = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] src_pend, pend;
  logic irq, dma_busy;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m_src = 0, m_mask = 0;

  always #2.5 clk = ~clk;

  uart_irq_combiner #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_tmo_en(rx_tmo_en),
    .rx_mode(rx_mode), .rx_count(rx_count), .rx_thresh(rx_thresh),
    .tx_count(tx_count), .tx_thresh(tx_thresh), .rx_ready(rx_ready),
    .rx_tmo_evt(rx_tmo_evt), .rx_err_evt(rx_err_evt), .modem_evt(modem_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_pend(src_pend), .pend(pend), .irq(irq), .dma_busy(dma_busy));

  function automatic logic [3:0] exp_set();
    logic [3:0] s;
    s = 4'b0000;
    if (fifo_en) begin
      if (!(rx_count < rx_thresh)) s[0] = 1'b1;
      if (rx_count > 0 && rx_tmo_en == 1'b0) s[0] = 1'b1;
      if (!(tx_count > tx_thresh)) s[2] = 1'b1;
    end else if (rx_ready) begin
      s[0] = 1'b1;
    end
    if (rx_tmo_evt) s[0] = 1'b1;
    if (rx_err_evt) s[1] = 1'b1;
    if (modem_evt)  s[3] = 1'b1;
    return s;
  endfunction

  function automatic logic exp_busy();
    return rx_mode[1] && !rx_mode[0] && (rx_count == 0);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " src_pend"}, src_pend, m_src);
    chk({tag, " pend R1"}, pend, m_src & ~m_mask);
    chk({tag, " irq R1"}, {3'b0, irq}, {3'b0, (m_src & ~m_mask) != 0});
    chk({tag, " dma_busy R12"}, {3'b0, dma_busy}, {3'b0, exp_busy()});
  endtask

  // one clock: update the model at the edge, then compare
  task automatic tick(input string tag);
    logic [3:0] clr;
    @(posedge clk);
    clr = (wr_en && !wr_sel[1]) ? wr_data : 4'b0;
    if (rst_n) begin
      m_src = (m_src & ~clr) | exp_set();
      if (wr_en && wr_sel == 2'b10) m_mask = wr_data;
    end else begin
      m_src = 0;
      m_mask = 0;
    end
    #1;
    cmp_all(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    fifo_en = 0; rx_ready = 0; rx_tmo_evt = 0; rx_err_evt = 0;
    modem_evt = 0; wr_en = 0; rx_count = 0; rx_mode = 0;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) tick("R13 in reset");
    chk("R13 src zero", src_pend, 4'b0);
    chk("R13 irq low", {3'b0, irq}, 4'b0);
    @(negedge clk); rst_n = 1;
    tick("R13 after reset");
    chk("R13 pend zero", pend, 4'b0);

    // R5: non-FIFO receive, counts ignored
    @(negedge clk);
    rx_ready = 1; rx_count = 9; rx_thresh = 1; tx_count = 0; tx_thresh = 5;
    tick("R5");
    chk("R5 only rx bit", src_pend, 4'b0001);

    // R7: sticky after cause drops
    @(negedge clk); rx_ready = 0;
    tick("R7");
    chk("R7 rx bit held", src_pend, 4'b0001);

    // R11: set and clear together on bit 0
    @(negedge clk); rx_ready = 1; wr_en = 1; wr_sel = 2'b00; wr_data = 4'b0001;
    tick("R11");
    chk("R11 set wins", src_pend, 4'b0001);

    // R8: pending-register clear
    @(negedge clk); rx_ready = 0;
    tick("R8");
    chk("R8 cleared", src_pend, 4'b0000);
    chk("R8 pend cleared", pend, 4'b0000);

    // R6: event pulses, R9 source clear
    @(negedge clk); wr_en = 0; rx_err_evt = 1; modem_evt = 1; rx_tmo_evt = 1;
    tick("R6");
    chk("R6 all events", src_pend, 4'b1011);
    @(negedge clk); rx_err_evt = 0; modem_evt = 0; rx_tmo_evt = 0;
    wr_en = 1; wr_sel = 2'b01; wr_data = 4'b1010;
    tick("R9");
    chk("R9 source clear", src_pend, 4'b0001);

    // R10: mask write takes effect after the edge
    @(negedge clk); wr_sel = 2'b10; wr_data = 4'b0001;
    #1;
    chk("R10 irq before mask edge", {3'b0, irq}, 4'b0001);
    tick("R10");
    chk("R10 masked pend", pend, 4'b0000);
    chk("R10 irq masked", {3'b0, irq}, 4'b0000);

    // R14: select 11 does nothing
    @(negedge clk); wr_sel = 2'b11; wr_data = 4'b1111;
    tick("R14");
    chk("R14 src kept", src_pend, 4'b0001);
    chk("R14 mask kept", pend, 4'b0000);
    @(negedge clk); wr_en = 1; wr_sel = 2'b10; wr_data = 4'b0000;
    tick("R10 unmask");
    chk("R10 unmasked irq", {3'b0, irq}, 4'b0001);

    // R2/R3/R4: FIFO thresholds
    @(negedge clk); wr_en = 1; wr_sel = 2'b00; wr_data = 4'b1111;
    tick("clear all");
    @(negedge clk); wr_en = 0; fifo_en = 1; rx_tmo_en = 1;
    rx_count = 3; rx_thresh = 4; tx_count = 6; tx_thresh = 5;
    tick("R3 below");
    chk("R3 below threshold no rx", src_pend, 4'b0000);
    @(negedge clk); rx_count = 4; tx_count = 5;
    tick("R2 R3 at");
    chk("R2 R3 at threshold", src_pend, 4'b0101);
    @(negedge clk); wr_en = 1; wr_sel = 2'b00; wr_data = 4'b0101;
    rx_count = 1; tx_count = 9; rx_tmo_en = 0;
    tick("R4");
    chk("R4 any data timeout off", src_pend, 4'b0001);

    // R12: DMA busy
    @(negedge clk); wr_en = 0; rx_mode = 2'b10; rx_count = 0;
    #1; chk("R12 busy empty", {3'b0, dma_busy}, 4'b0001);
    @(negedge clk); rx_count = 2;
    #1; chk("R12 not busy data", {3'b0, dma_busy}, 4'b0000);
    @(negedge clk); rx_mode = 2'b01; rx_count = 0;
    #1; chk("R12 not busy mode", {3'b0, dma_busy}, 4'b0000);

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      fifo_en    = ($urandom % 4) != 0;
      rx_tmo_en  = $urandom % 2;
      rx_mode    = $urandom % 4;
      rx_count   = CW'($urandom % (DEPTH + 1));
      rx_thresh  = CW'($urandom % (DEPTH + 1));
      tx_count   = CW'($urandom % (DEPTH + 1));
      tx_thresh  = CW'($urandom % (DEPTH / 2));
      rx_ready   = ($urandom % 5) == 0;
      rx_tmo_evt = ($urandom % 10) == 0;
      rx_err_evt = ($urandom % 10) == 0;
      modem_evt  = ($urandom % 10) == 0;
      wr_en      = ($urandom % 3) == 0;
      wr_sel     = $urandom % 4;
      wr_data    = $urandom % 16;
      tick("R1 R7 random");
    end
    idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule